// File: doc/BRIEF.md
# Clock Fan-Out Mode and Reference-Loss Controller

This block is the digital control for a zero-delay clock fan-out buffer. Two select pins choose the clock source and which outputs are driven. The source is either the phase-locked loop or a direct pass of the reference clock. There are two banks of four outputs and one feedback output that closes the loop. The block does not carry the clocks. It drives three things: the loop power-down line, the source multiplexer select, and one output-enable line for each bank and for the feedback pad.

A free-running detection clock samples the reference clock through a two-flop synchroniser, which turns each reference rise into a single-cycle pulse. A saturating counter measures the detection-clock cycles since the last rise. When that count reaches `IDLE_CYCLES`, the block enters power-down: the loop is switched off and every output, feedback included, is tri-stated. The first reference rise seen in power-down wakes the block. In a loop mode the enables then wait for the loop's lock flag. In bypass mode the enables come on at once.

The select pins pass through their own two-flop synchroniser before they are decoded. The controller has four states. POWER_DOWN is entered from any state on idle, and left on a reference rise, to WAIT_LOCK or to ACTIVE_BYPASS. WAIT_LOCK moves to ACTIVE_PLL on lock, or to ACTIVE_BYPASS on a bypass select. ACTIVE_PLL returns to WAIT_LOCK on lock loss, and moves to ACTIVE_BYPASS on a bypass select. ACTIVE_BYPASS leaves on a non-bypass select, to ACTIVE_PLL if the loop is locked and to WAIT_LOCK if it is not.

Top module: `zdb_mode_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, `pll_pd_o`=1, `src_ref_o`=0, and all three enables are 0.
- R2: Select code 00 (`sel_i[1]`=0, `sel_i[0]`=0) with a locked loop and an active reference: both banks are off, the feedback enable is on, `src_ref_o`=0 and `pll_pd_o`=0.
- R3: Select code 01 with a locked loop: bank A is on, bank B is off, the feedback enable is on, and the loop source is used with the loop running.
- R4: Select code 11, which is also the level that floating select pins pull to and the synchroniser's reset value: both banks and the feedback output are enabled from the running loop.
- R5: Select code 10: `src_ref_o`=1, `pll_pd_o`=1 and all three enables are on, whatever the state of `pll_lock_i`.
- R6: The block stays out of power-down while reference rises keep arriving less than `IDLE_CYCLES` detection cycles apart. Once rises stop, it enters power-down (`pll_pd_o`=1, all enables 0) within `IDLE_CYCLES`+4 cycles of the last rise.
- R7: In a loop mode, the first reference rise seen in power-down clears `pll_pd_o`. The enables stay off until `pll_lock_i` is high.
- R8: In a loop mode, if `pll_lock_i` drops, all enables go off on the next cycle while `pll_pd_o` stays 0.
- R9: With select code 10, a reference rise in power-down enables every output without waiting for lock.
- R10: Leaving code 10 for a loop code while `pll_lock_i` is low holds all enables off, with `pll_pd_o`=0, until lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running detection clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk_i | input | 1 | Reference clock, asynchronous to `clk` |
| sel_i | input | 2 | Mode select; bit 1 is the high-order select pin |
| pll_lock_i | input | 1 | Loop lock flag |
| pll_pd_o | output | 1 | Loop power-down, active high |
| src_ref_o | output | 1 | Source select: 1 = reference bypass, 0 = loop |
| bank_a_oe_o | output | 1 | Output enable for bank A |
| bank_b_oe_o | output | 1 | Output enable for bank B |
| fb_oe_o | output | 1 | Output enable for the feedback output |

## Verification
The bench builds the block with `IDLE_CYCLES`=32 and toggles the reference every four detection cycles. This puts reference rises eight cycles apart, well inside the idle limit, so the power-down timeout can be hit within a few dozen cycles of stopping the reference. It also lets the bench check both sides of the timeout: still active 16 cycles after the stop, and in power-down 50 cycles after it. The short limit makes wake-up from power-down into each of the loop and bypass paths cheap to repeat, and the same goes for lock loss and for leaving bypass before the loop has locked.

// File: rtl/zdb_pkg.sv
package zdb_pkg;

    typedef enum logic [1:0] {
        ST_POWER_DOWN    = 2'd0,
        ST_WAIT_LOCK     = 2'd1,
        ST_ACTIVE_PLL    = 2'd2,
        ST_ACTIVE_BYPASS = 2'd3
    } zdb_state_t;

    typedef struct packed {
        logic bypass;
        logic bank_a;
        logic bank_b;
        logic fb;
    } zdb_mode_t;

    localparam int unsigned SEL_W = 2;
    localparam logic [SEL_W-1:0] SEL_PULLUP = 2'b11;

endpackage

// File: rtl/zdb_sync2.sv
module zdb_sync2 #(
    parameter int unsigned W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            stage2 <= RST_VAL;
        end else begin
            stage1 <= d_i;
            stage2 <= stage1;
        end
    end

    assign q_o = stage2;
endmodule

// File: rtl/zdb_edge_watch.sv
module zdb_edge_watch #(
    parameter int unsigned IDLE_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_i,
    output logic rise_o,
    output logic idle_o
);
    localparam int unsigned CW = $clog2(IDLE_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYCLES);

    logic          ref_s;
    logic          ref_prev;
    logic [CW-1:0] gap_cnt;

    zdb_sync2 #(.W(1), .RST_VAL(1'b0)) u_ref_sync (
        .clk (clk),
        .rst (rst),
        .d_i (ref_i),
        .q_o (ref_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_prev <= 1'b0;
        end else begin
            ref_prev <= ref_s;
        end
    end

    assign rise_o = ref_s & ~ref_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_cnt <= LIMIT;
        end else if (rise_o) begin
            gap_cnt <= '0;
        end else if (gap_cnt != LIMIT) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    assign idle_o = (gap_cnt == LIMIT);

    // R6
    rise_clears_idle_chk: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !idle_o);

    // R6
    idle_sticks_chk: assert property (@(posedge clk) disable iff (rst)
        (idle_o && !rise_o) |=> idle_o);
endmodule

// File: rtl/zdb_sel_decode.sv
module zdb_sel_decode
    import zdb_pkg::*;
(
    input  logic [SEL_W-1:0] sel_i,
    output zdb_mode_t        mode_o
);
    always_comb begin
        mode_o = '0;
        unique case (sel_i)
            2'b00: begin
                mode_o.fb = 1'b1;
            end
            2'b01: begin
                mode_o.bank_a = 1'b1;
                mode_o.fb     = 1'b1;
            end
            2'b10: begin
                mode_o.bypass = 1'b1;
                mode_o.bank_a = 1'b1;
                mode_o.bank_b = 1'b1;
                mode_o.fb     = 1'b1;
            end
            default: begin
                mode_o.bank_a = 1'b1;
                mode_o.bank_b = 1'b1;
                mode_o.fb     = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/zdb_mode_ctrl.sv
module zdb_mode_ctrl
    import zdb_pkg::*;
#(
    parameter int unsigned IDLE_CYCLES = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_clk_i,
    input  logic [1:0] sel_i,
    input  logic       pll_lock_i,
    output logic       pll_pd_o,
    output logic       src_ref_o,
    output logic       bank_a_oe_o,
    output logic       bank_b_oe_o,
    output logic       fb_oe_o
);
    logic             ref_rise;
    logic             ref_idle;
    logic [SEL_W-1:0] sel_s;
    zdb_mode_t        mode;
    zdb_state_t       state, state_nx;

    zdb_edge_watch #(.IDLE_CYCLES(IDLE_CYCLES)) u_watch (
        .clk    (clk),
        .rst    (rst),
        .ref_i  (ref_clk_i),
        .rise_o (ref_rise),
        .idle_o (ref_idle)
    );

    zdb_sync2 #(.W(SEL_W), .RST_VAL(SEL_PULLUP)) u_sel_sync (
        .clk (clk),
        .rst (rst),
        .d_i (sel_i),
        .q_o (sel_s)
    );

    zdb_sel_decode u_dec (
        .sel_i  (sel_s),
        .mode_o (mode)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_POWER_DOWN: begin
                if (ref_rise) begin
                    state_nx = mode.bypass ? ST_ACTIVE_BYPASS : ST_WAIT_LOCK;
                end
            end
            ST_WAIT_LOCK: begin
                if (ref_idle)         state_nx = ST_POWER_DOWN;
                else if (mode.bypass) state_nx = ST_ACTIVE_BYPASS;
                else if (pll_lock_i)  state_nx = ST_ACTIVE_PLL;
            end
            ST_ACTIVE_PLL: begin
                if (ref_idle)         state_nx = ST_POWER_DOWN;
                else if (mode.bypass) state_nx = ST_ACTIVE_BYPASS;
                else if (!pll_lock_i) state_nx = ST_WAIT_LOCK;
            end
            ST_ACTIVE_BYPASS: begin
                if (ref_idle)          state_nx = ST_POWER_DOWN;
                else if (!mode.bypass) state_nx = pll_lock_i ? ST_ACTIVE_PLL : ST_WAIT_LOCK;
            end
            default: state_nx = ST_POWER_DOWN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_POWER_DOWN;
        else     state <= state_nx;
    end

    always_comb begin
        pll_pd_o    = 1'b0;
        src_ref_o   = 1'b0;
        bank_a_oe_o = 1'b0;
        bank_b_oe_o = 1'b0;
        fb_oe_o     = 1'b0;
        unique case (state)
            ST_POWER_DOWN: begin
                pll_pd_o = 1'b1;
            end
            ST_WAIT_LOCK: begin
            end
            ST_ACTIVE_PLL: begin
                bank_a_oe_o = mode.bank_a;
                bank_b_oe_o = mode.bank_b;
                fb_oe_o     = mode.fb;
            end
            ST_ACTIVE_BYPASS: begin
                pll_pd_o    = 1'b1;
                src_ref_o   = 1'b1;
                bank_a_oe_o = 1'b1;
                bank_b_oe_o = 1'b1;
                fb_oe_o     = 1'b1;
            end
            default: pll_pd_o = 1'b1;
        endcase
    end

    // R5
    bypass_drives_all_chk: assert property (@(posedge clk) disable iff (rst)
        src_ref_o |-> (pll_pd_o && bank_a_oe_o && bank_b_oe_o && fb_oe_o));

    // R6
    pd_tristate_chk: assert property (@(posedge clk) disable iff (rst)
        (pll_pd_o && !src_ref_o) |-> !(bank_a_oe_o || bank_b_oe_o || fb_oe_o));

    // R7
    lock_gates_oe_chk: assert property (@(posedge clk) disable iff (rst)
        (fb_oe_o && !src_ref_o) |-> $past(pll_lock_i));

    // R7
    wake_releases_pll_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_POWER_DOWN && ref_rise && !mode.bypass) |=> !pll_pd_o);

    // R3
    bank_b_needs_a_chk: assert property (@(posedge clk) disable iff (rst)
        bank_b_oe_o |-> bank_a_oe_o);
endmodule

// File: tb/zdb_mode_ctrl_tb.sv
module zdb_mode_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_clk = 1'b0;
    logic [1:0] sel = 2'b11;
    logic       lock = 1'b0;
    logic       pll_pd, src_ref, a_oe, b_oe, fb_oe;
    logic       ref_run = 1'b0;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    zdb_mode_ctrl #(.IDLE_CYCLES(32)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .ref_clk_i   (ref_clk),
        .sel_i       (sel),
        .pll_lock_i  (lock),
        .pll_pd_o    (pll_pd),
        .src_ref_o   (src_ref),
        .bank_a_oe_o (a_oe),
        .bank_b_oe_o (b_oe),
        .fb_oe_o     (fb_oe)
    );

    // reference generator: toggles every 4 detection cycles while running
    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            if (ref_run) begin
                div = div + 1;
                if (div == 4) begin
                    div = 0;
                    ref_clk = ~ref_clk;
                end
            end else begin
                div = 0;
                ref_clk = 1'b0;
            end
        end
    end

    // vector: {sel[1:0], lock, expected {pd, src, a, b, fb}}
    localparam logic [7:0] VEC [10] = '{
        {2'b11, 1'b1, 5'b00111},
        {2'b01, 1'b1, 5'b00101},
        {2'b00, 1'b1, 5'b00001},
        {2'b10, 1'b1, 5'b11111},
        {2'b10, 1'b0, 5'b11111},
        {2'b11, 1'b0, 5'b00000},
        {2'b11, 1'b1, 5'b00111},
        {2'b00, 1'b0, 5'b00000},
        {2'b01, 1'b1, 5'b00101},
        {2'b11, 1'b1, 5'b00111}
    };

    function automatic string vec_tag(input logic [1:0] s, input logic lk);
        if (s == 2'b10)  return "R5";
        if (!lk)         return "R8/R10";
        if (s == 2'b00)  return "R2";
        if (s == 2'b01)  return "R3";
        return "R4";
    endfunction

    task automatic chk(input string tag, input logic [4:0] exp);
        logic [4:0] act;
        act = {pll_pd, src_ref, a_oe, b_oe, fb_oe};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {pd,src,a,b,fb} actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        wait_cyc(3);
        chk("R1 in reset", 5'b10000);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", 5'b10000);
        wait_cyc(20);
        chk("R6 no reference stays down", 5'b10000);

        // R7: wake in loop mode, enables held until lock
        ref_run = 1'b1;
        wait_cyc(20);
        chk("R7 pll released, no lock", 5'b00000);
        lock = 1'b1;
        wait_cyc(2);
        chk("R7 locked enables", 5'b00111);

        // vector table
        for (int v = 0; v < 10; v++) begin
            sel  = VEC[v][7:6];
            lock = VEC[v][5];
            wait_cyc(6);
            chk(vec_tag(VEC[v][7:6], VEC[v][5]), VEC[v][4:0]);
        end

        // R8: lock loss in PLL mode takes one cycle
        lock = 1'b0;
        wait_cyc(1);
        chk("R8 lock loss", 5'b00000);
        lock = 1'b1;
        wait_cyc(2);
        chk("R8 relock", 5'b00111);

        // R6: reference stops; active before timeout, down after
        ref_run = 1'b0;
        wait_cyc(16);
        chk("R6 before timeout", 5'b00111);
        wait_cyc(34);
        chk("R6 after timeout", 5'b10000);

        // R9: wake in bypass mode without lock
        lock = 1'b0;
        sel  = 2'b10;
        wait_cyc(4);
        chk("R9 bypass select while down", 5'b10000);
        ref_run = 1'b1;
        wait_cyc(20);
        chk("R9 bypass wake", 5'b11111);

        // R10: leave bypass with no lock
        sel = 2'b01;
        wait_cyc(5);
        chk("R10 leave bypass unlocked", 5'b00000);
        lock = 1'b1;
        wait_cyc(2);
        chk("R10 locked after bypass", 5'b00101);

        // R1: reset mid-run
        rst = 1'b1;
        wait_cyc(2);
        chk("R1 reset mid-run", 5'b10000);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 first cycle after reset", 5'b10000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule